// File: doc/BRIEF.md
# DRAM Periodic Refresh Scheduler

This block paces refresh work for a DRAM controller. It counts system clock cycles against a per-row refresh period, which is derived from the clock frequency and a period in nanoseconds given as parameters. Each time the period elapses, one more refresh becomes owed. A request stays raised while any refresh is owed. Each acknowledge from the controller retires one owed refresh. The owed count is visible, so the controller can postpone refreshes behind traffic and later drain them in a burst.

With the default settings (200 MHz clock, 15.625 µs per row) the period is 3125 cycles, so 1024 rows are swept in about 16 ms. For controllers that refresh by opening a row without a column strobe, the block keeps the address of the next row to refresh and steps it once per retired refresh. Controllers that use an internal row counter in the DRAM simply leave that output unconnected. The controller is responsible for producing the actual strobe waveforms.

Top module: `refresh_pacer`

## Requirements
- R1: While reset is low, and right after it is released, the owed count is 0, the request is low, the row pointer is 0 and the overflow flag is low.
- R2: The interval is INTERVAL = CLK_KHZ*PERIOD_NS/1000000 clock cycles. After reset is released, the owed count rises by one after exactly INTERVAL rising edges, and again every INTERVAL edges after that.
- R3: The request output is high exactly when the owed count is nonzero.
- R4: An acknowledge sampled while the request is high lowers the owed count by one and advances the row pointer by one.
- R5: An acknowledge sampled while the owed count is 0 changes neither the owed count nor the row pointer.
- R6: When an interval expires in the same cycle as an accepted acknowledge, the owed count stays the same and the row pointer advances.
- R7: The owed count never exceeds MAX_OWED. An interval that expires at MAX_OWED without an accepted acknowledge leaves the count at MAX_OWED and sets the overflow flag. The flag stays set until reset.
- R8: The row pointer wraps from ROWS-1 to 0, so ROWS need not be a power of two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_ack | input | 1 | Controller has issued one refresh |
| ref_req | output | 1 | At least one refresh is owed |
| owed | output | $clog2(MAX_OWED+1) | Number of refreshes owed |
| overflow | output | 1 | Sticky flag: a refresh was lost at saturation |
| row | output | $clog2(ROWS) (minimum 1) | Next row address for explicit-row refresh |

## Verification
Two events can land on the same rising edge: an interval expiry, which adds a refresh, and an accepted acknowledge, which retires one. The bench counts edges from reset and places an acknowledge exactly on an expiry edge. It then expects the owed count to stay the same while the row pointer steps. The same edge counting drives the count to saturation, and one further expiry must set the overflow flag without raising the count. An acknowledge on the following edge must then lower the count while the flag stays set.

// File: rtl/refresh_pacer.sv
module refresh_pacer #(
  parameter int CLK_KHZ   = 200000,
  parameter int PERIOD_NS = 15625,
  parameter int ROWS      = 1024,
  parameter int MAX_OWED  = 15,
  localparam int INTERVAL = int'((64'(CLK_KHZ) * 64'(PERIOD_NS)) / 64'd1000000),
  localparam int TW       = $clog2(INTERVAL + 1),
  localparam int OW       = $clog2(MAX_OWED + 1),
  localparam int RW       = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_ack,
  output logic          ref_req,
  output logic [OW-1:0] owed,
  output logic          overflow,
  output logic [RW-1:0] row
);

  logic [TW-1:0] timer;
  logic tick, take;

  assign tick    = timer == TW'(INTERVAL - 1);
  assign take    = ref_ack && owed != '0;
  assign ref_req = owed != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer    <= '0;
      owed     <= '0;
      overflow <= 1'b0;
      row      <= '0;
    end else begin
      timer <= tick ? '0 : timer + 1'b1;
      if (take)
        row <= (row == RW'(ROWS - 1)) ? '0 : row + 1'b1;
      if (tick && !take) begin
        if (owed == OW'(MAX_OWED)) overflow <= 1'b1;
        else                       owed     <= owed + 1'b1;
      end else if (take && !tick) begin
        owed <= owed - 1'b1;
      end
    end
  end

endmodule

module refresh_pacer_chk #(
  parameter int ROWS     = 1024,
  parameter int MAX_OWED = 15,
  parameter int OW       = 4,
  parameter int RW       = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_ack,
  input logic          ref_req,
  input logic [OW-1:0] owed,
  input logic          overflow,
  input logic [RW-1:0] row
);

  a_r7_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(owed) <= MAX_OWED);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r4_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_ack) |=>
      int'(row) == ((int'($past(row)) == ROWS - 1) ? 0 : int'($past(row)) + 1));

  a_r5_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_req) |=> row == $past(row));

  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (int'(owed) - int'($past(owed)) <= 1) && (int'($past(owed)) - int'(owed) <= 1));

  a_r4_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_ack) |=> int'(owed) >= int'($past(owed)));

endmodule

bind refresh_pacer refresh_pacer_chk #(
  .ROWS(ROWS), .MAX_OWED(MAX_OWED), .OW(OW), .RW(RW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack), .ref_req(ref_req),
  .owed(owed), .overflow(overflow), .row(row)
);

// File: tb/sim_refresh_pacer.sv
`timescale 1ns/1ps
module sim_refresh_pacer;
  logic clk = 1'b0, rst_n = 1'b0, ref_ack = 1'b0;
  logic ref_req, overflow;
  logic [1:0] owed, row;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  refresh_pacer #(.CLK_KHZ(1000), .PERIOD_NS(8000), .ROWS(3), .MAX_OWED(3)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack), .ref_req(ref_req),
    .owed(owed), .overflow(overflow), .row(row));

  // [9:6] idle edges after optional ack, [5] ack pulse, [4:3] owed, [2:1] row, [0] overflow
  localparam logic [9:0] VEC [16] = '{
    {4'd7, 1'b0, 2'd0, 2'd0, 1'b0},  // E7  R2 no tick yet
    {4'd1, 1'b0, 2'd1, 2'd0, 1'b0},  // E8  R2 first tick
    {4'd0, 1'b1, 2'd0, 2'd1, 1'b0},  // E9  R4
    {4'd7, 1'b0, 2'd1, 2'd1, 1'b0},  // E16 R2
    {4'd8, 1'b0, 2'd2, 2'd1, 1'b0},  // E24 R2
    {4'd0, 1'b1, 2'd1, 2'd2, 1'b0},  // E25 R4
    {4'd0, 1'b1, 2'd0, 2'd0, 1'b0},  // E26 R8 wrap
    {4'd0, 1'b1, 2'd0, 2'd0, 1'b0},  // E27 R5 ignored
    {4'd5, 1'b0, 2'd1, 2'd0, 1'b0},  // E32
    {4'd7, 1'b0, 2'd1, 2'd0, 1'b0},  // E39
    {4'd0, 1'b1, 2'd1, 2'd1, 1'b0},  // E40 R6 tick with ack
    {4'd8, 1'b0, 2'd2, 2'd1, 1'b0},  // E48
    {4'd8, 1'b0, 2'd3, 2'd1, 1'b0},  // E56
    {4'd7, 1'b0, 2'd3, 2'd1, 1'b0},  // E63 R7 at max
    {4'd1, 1'b0, 2'd3, 2'd1, 1'b1},  // E64 R7 overflow
    {4'd0, 1'b1, 2'd2, 2'd2, 1'b1}   // E65 R7 sticky
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input int eo, input int er, input int ev);
    chk({tag, " owed"}, int'(owed), eo);
    chk({"R3 ", tag, " req"}, int'(ref_req), int'(eo != 0));
    chk({tag, " row"}, int'(row), er);
    chk({tag, " overflow"}, int'(overflow), ev);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R1 in reset", 0, 0, 0);
    rst_n = 1'b1;
    chk_all("R1 after release", 0, 0, 0);
    for (int i = 0; i < 16; i++) begin
      if (VEC[i][5]) begin
        ref_ack = 1'b1;
        @(negedge clk);
        ref_ack = 1'b0;
      end
      repeat (int'(VEC[i][9:6])) @(negedge clk);
      chk_all($sformatf("step %0d", i), int'(VEC[i][4:3]), int'(VEC[i][2:1]), int'(VEC[i][0]));
    end
    rst_n = 1'b0;
    @(negedge clk);
    chk_all("R1 mid-run reset", 0, 0, 0);
    rst_n = 1'b1;
    ref_ack = 1'b1;
    repeat (7) @(negedge clk);
    chk_all("R5 ack held idle", 0, 0, 0);
    ref_ack = 1'b0;
    @(negedge clk);
    chk_all("R2 tick after reset", 1, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule